// File: doc/BRIEF.md
# Floating-Point Class Test Unit

This block checks one floating-point operand against a class-select mask and returns a 4-bit condition field that later logic can use as a predicate. The operand comes from a 64-bit register. A precision select picks either the low 32-bit word as a single-precision value or the full register as a double-precision value. The block splits the operand into sign, exponent and fraction and sorts it into one of four special classes: NaN, infinity, zero or denormal. Ordinary finite values fall into none of them.

An 8-bit mask enables each class separately for each sign. The mask is built from a 7-bit field and one trailing bit. A class bit in the result is set when the operand's class is enabled for the operand's sign. The result is registered on an input strobe and appears one clock later with an output valid. A 3-bit condition-field index travels with the result, so the consumer can choose where to write it.

Top module: `fpcls_unit`

## Requirements
- R1: When `is_double` is 0, only `operand[31:0]` is examined: sign is `operand[31]`, exponent is `operand[30:23]` and fraction is `operand[22:0]`. Bits `operand[63:32]` have no effect on the result.
- R2: When `is_double` is 1, sign is `operand[63]`, exponent is `operand[62:52]` and fraction is `operand[51:0]`.
- R3: An exponent of all ones with a zero fraction is infinity, and with a nonzero fraction it is NaN. An exponent of zero with a zero fraction is zero, and with a nonzero fraction it is denormal. Any other exponent matches no class and gives a result of 0000.
- R4: The mask is `{mask_field[6:0], mask_tail}`. Counting mask bit 0 as its MSB, bits 0 and 1 enable positive and negative NaN, bits 2 and 3 enable positive and negative infinity, bits 4 and 5 enable positive and negative zero, and bits 6 and 7 enable positive and negative denormal.
- R5: In `out_cond`, bit 3 is the NaN match, bit 2 the denormal match, bit 1 the infinity match and bit 0 the zero match. Each match is the OR of its positive-sign and negative-sign terms, and at most one bit is set.
- R6: An all-zero mask always gives 0000. An all-ones mask gives the operand's class bit whatever its sign.
- R7: A sample taken on a clock edge with `in_valid` high appears on `out_cond` with `out_valid` high right after that edge. `out_valid` is low after any edge where `in_valid` was low.
- R8: While `in_valid` is low, `out_cond` and `out_cr_idx` hold their last values.
- R9: `out_cr_idx` equals the `cr_idx` sampled together with the operand.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_cond` and `out_cr_idx` to zero, and it takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for the operand and controls |
| operand | input | 64 | Register value under test |
| is_double | input | 1 | 1 selects double precision, 0 selects single precision |
| mask_field | input | 7 | Upper seven bits of the class mask |
| mask_tail | input | 1 | Least significant bit of the class mask |
| cr_idx | input | 3 | Target condition-field index, passed through |
| out_valid | output | 1 | Result valid |
| out_cond | output | 4 | Match bits {NaN, denormal, infinity, zero} |
| out_cr_idx | output | 3 | Index sampled with the operand |

## Verification
Every class is applied with both signs in both precisions. Each of these operands is driven with an all-ones mask, an all-zero mask and each of the eight single-bit masks. The single-bit masks show that the right sign half of the right mask pair is decoded, and that the result lands in the right bit. Normal values in both precisions confirm that finite numbers never match. A single-precision infinity with garbage in the upper word separates the two field layouts: read as a double, the same register is a negative normal number.

// File: rtl/fpcls_pkg.sv
package fpcls_pkg;

    // Class hits, packed so that casting to 4 bits gives the result order.
    typedef struct packed {
        logic nan;
        logic denorm;
        logic inf;
        logic zero;
    } cls_t;

    localparam int unsigned NUM_CLS = 4;
    localparam int unsigned MASK_W  = 2 * NUM_CLS;

    // Position of each class's pair in the mask (MSB-0 pair index).
    localparam int unsigned PAIR_NAN  = 0;
    localparam int unsigned PAIR_INF  = 1;
    localparam int unsigned PAIR_ZERO = 2;
    localparam int unsigned PAIR_DEN  = 3;

endpackage

// File: rtl/fpcls_fmt_decode.sv
module fpcls_fmt_decode #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned FMT_W = 1 + EXP_W + FRAC_W
) (
    input  logic [FMT_W-1:0] value,
    output logic             sign,
    output logic             exp_ones,
    output logic             exp_zero,
    output logic             frac_nz
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        sign     = value[FMT_W-1];
        exp_f    = value[FMT_W-2 -: EXP_W];
        frac_f   = value[FRAC_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        frac_nz  = |frac_f;
    end

endmodule

// File: rtl/fpcls_split.sv
module fpcls_split #(
    parameter int unsigned REG_W     = 64,
    parameter int unsigned SP_EXP_W  = 8,
    parameter int unsigned SP_FRAC_W = 23,
    parameter int unsigned DP_EXP_W  = 11,
    parameter int unsigned DP_FRAC_W = 52,
    localparam int unsigned SP_W     = 1 + SP_EXP_W + SP_FRAC_W
) (
    input  logic [REG_W-1:0] operand,
    input  logic             is_double,
    output logic             sign,
    output logic             exp_ones,
    output logic             exp_zero,
    output logic             frac_nz
);

    logic sp_sign, sp_ones, sp_zero, sp_fnz;
    logic dp_sign, dp_ones, dp_zero, dp_fnz;

    fpcls_fmt_decode #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) sp_dec_i (
        .value    (operand[SP_W-1:0]),
        .sign     (sp_sign),
        .exp_ones (sp_ones),
        .exp_zero (sp_zero),
        .frac_nz  (sp_fnz)
    );

    fpcls_fmt_decode #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) dp_dec_i (
        .value    (operand),
        .sign     (dp_sign),
        .exp_ones (dp_ones),
        .exp_zero (dp_zero),
        .frac_nz  (dp_fnz)
    );

    always_comb begin
        if (is_double) begin
            sign     = dp_sign;
            exp_ones = dp_ones;
            exp_zero = dp_zero;
            frac_nz  = dp_fnz;
        end else begin
            sign     = sp_sign;
            exp_ones = sp_ones;
            exp_zero = sp_zero;
            frac_nz  = sp_fnz;
        end
    end

endmodule

// File: rtl/fpcls_classify.sv
module fpcls_classify
    import fpcls_pkg::*;
(
    input  logic exp_ones,
    input  logic exp_zero,
    input  logic frac_nz,
    output cls_t cls
);

    always_comb begin
        cls.inf    = exp_ones & ~frac_nz;
        cls.nan    = exp_ones &  frac_nz;
        cls.zero   = exp_zero & ~frac_nz;
        cls.denorm = exp_zero &  frac_nz;
    end

endmodule

// File: rtl/fpcls_match.sv
module fpcls_match
    import fpcls_pkg::*;
(
    input  logic [MASK_W-1:0]  mask,
    input  logic               sign,
    input  cls_t               cls,
    output logic [NUM_CLS-1:0] cond
);

    logic [NUM_CLS-1:0] hit_by_pair;
    logic [NUM_CLS-1:0] pair_match;

    always_comb begin
        hit_by_pair[PAIR_NAN]  = cls.nan;
        hit_by_pair[PAIR_INF]  = cls.inf;
        hit_by_pair[PAIR_ZERO] = cls.zero;
        hit_by_pair[PAIR_DEN]  = cls.denorm;
    end

    // Mask bit k in MSB-0 terms is mask[MASK_W-1-k]; pair p covers k = 2p, 2p+1.
    for (genvar p = 0; p < NUM_CLS; p++) begin : g_pair
        localparam int unsigned POS_IDX = MASK_W - 1 - 2 * p;
        localparam int unsigned NEG_IDX = MASK_W - 2 - 2 * p;
        always_comb begin
            pair_match[p] = hit_by_pair[p] &
                            ((~sign & mask[POS_IDX]) | (sign & mask[NEG_IDX]));
        end
    end

    always_comb begin
        cond = {pair_match[PAIR_NAN], pair_match[PAIR_DEN],
                pair_match[PAIR_INF], pair_match[PAIR_ZERO]};
    end

endmodule

// File: rtl/fpcls_unit.sv
module fpcls_unit
    import fpcls_pkg::*;
#(
    parameter int unsigned REG_W     = 64,
    parameter int unsigned SP_EXP_W  = 8,
    parameter int unsigned SP_FRAC_W = 23,
    parameter int unsigned DP_EXP_W  = 11,
    parameter int unsigned DP_FRAC_W = 52,
    parameter int unsigned CR_IDX_W  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [REG_W-1:0]    operand,
    input  logic                is_double,
    input  logic [MASK_W-2:0]   mask_field,
    input  logic                mask_tail,
    input  logic [CR_IDX_W-1:0] cr_idx,
    output logic                out_valid,
    output logic [NUM_CLS-1:0]  out_cond,
    output logic [CR_IDX_W-1:0] out_cr_idx
);

    typedef struct packed {
        logic                vld;
        logic [NUM_CLS-1:0]  cond;
        logic [CR_IDX_W-1:0] idx;
    } stage_t;

    logic               op_sign, op_exp_ones, op_exp_zero, op_frac_nz;
    cls_t               op_cls;
    logic [MASK_W-1:0]  full_mask;
    logic [NUM_CLS-1:0] cond_comb;
    stage_t             st_d, st_q;

    assign full_mask = {mask_field, mask_tail};

    fpcls_split #(
        .REG_W     (REG_W),
        .SP_EXP_W  (SP_EXP_W),
        .SP_FRAC_W (SP_FRAC_W),
        .DP_EXP_W  (DP_EXP_W),
        .DP_FRAC_W (DP_FRAC_W)
    ) split_i (
        .operand   (operand),
        .is_double (is_double),
        .sign      (op_sign),
        .exp_ones  (op_exp_ones),
        .exp_zero  (op_exp_zero),
        .frac_nz   (op_frac_nz)
    );

    fpcls_classify classify_i (
        .exp_ones (op_exp_ones),
        .exp_zero (op_exp_zero),
        .frac_nz  (op_frac_nz),
        .cls      (op_cls)
    );

    fpcls_match match_i (
        .mask (full_mask),
        .sign (op_sign),
        .cls  (op_cls),
        .cond (cond_comb)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.cond = cond_comb;
            st_d.idx  = cr_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_cond   = st_q.cond;
    assign out_cr_idx = st_q.idx;

    // R3
    normal_no_match_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_exp_ones && !op_exp_zero) |=> (out_cond == '0));

    // R5
    single_class_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(out_cond));

    // R6
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && full_mask == '0) |=> (out_cond == '0));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_cond) && $stable(out_cr_idx)));

    // R9
    idx_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_cr_idx == $past(cr_idx)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_cond == '0 && out_cr_idx == '0));

endmodule

// File: tb/fpcls_unit_tb_top.sv
`timescale 1ns/1ps
module fpcls_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic        is_double = 1'b0;
    logic [6:0]  mask_field = '0;
    logic        mask_tail = 1'b0;
    logic [2:0]  cr_idx = '0;
    logic        out_valid;
    logic [3:0]  out_cond;
    logic [2:0]  out_cr_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] exp_cond_q[$];
    logic [2:0] exp_idx_q[$];
    string      exp_tag_q[$];

    always #2.5 clk = ~clk;

    fpcls_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .operand    (operand),
        .is_double  (is_double),
        .mask_field (mask_field),
        .mask_tail  (mask_tail),
        .cr_idx     (cr_idx),
        .out_valid  (out_valid),
        .out_cond   (out_cond),
        .out_cr_idx (out_cr_idx)
    );

    // Reference from the requirements: mask bit k (MSB-0) is m[7-k].
    function automatic logic [3:0] ref_cond(input logic [63:0] v, input logic dbl,
                                            input logic [7:0] m);
        logic       s, e1, e0, fn;
        logic [3:0] r;
        if (dbl) begin
            s  = v[63];
            e1 = (v[62:52] == 11'h7FF);
            e0 = (v[62:52] == 11'h000);
            fn = (v[51:0] != 52'd0);
        end else begin
            s  = v[31];
            e1 = (v[30:23] == 8'hFF);
            e0 = (v[30:23] == 8'h00);
            fn = (v[22:0] != 23'd0);
        end
        r    = 4'b0000;
        r[3] = e1 &  fn & m[7 - (0 + int'(s))];
        r[1] = e1 & !fn & m[7 - (2 + int'(s))];
        r[0] = e0 & !fn & m[7 - (4 + int'(s))];
        r[2] = e0 &  fn & m[7 - (6 + int'(s))];
        return r;
    endfunction

    function automatic void check(input bit ok, input string tag,
                                  input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    task automatic drive(input logic [63:0] v, input logic dbl, input logic [7:0] m,
                         input logic [2:0] idx, input string tag);
        @(negedge clk);
        operand    = v;
        is_double  = dbl;
        mask_field = m[7:1];
        mask_tail  = m[0];
        cr_idx     = idx;
        in_valid   = 1'b1;
        exp_cond_q.push_back(ref_cond(v, dbl, m));
        exp_idx_q.push_back(idx);
        exp_tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (out_valid) begin
                if (exp_cond_q.size() == 0) begin
                    check(1'b0, "R7 unexpected out_valid", 16'(out_cond), 16'h0);
                end else begin
                    logic [3:0] ec;
                    logic [2:0] ei;
                    string      et;
                    ec = exp_cond_q.pop_front();
                    ei = exp_idx_q.pop_front();
                    et = exp_tag_q.pop_front();
                    check(out_cond == ec, {et, " cond"}, 16'(out_cond), 16'(ec));
                    check(out_cr_idx == ei, {et, " R9 idx"}, 16'(out_cr_idx), 16'(ei));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [63:0] vals [18];
    logic        dbls [18];

    initial begin
        int n = 0;
        vals[0]  = 64'h0000_0000_7F80_0000; dbls[0]  = 1'b0; // +inf
        vals[1]  = 64'h0000_0000_FF80_0000; dbls[1]  = 1'b0; // -inf
        vals[2]  = 64'h0000_0000_7FC0_0000; dbls[2]  = 1'b0; // +nan
        vals[3]  = 64'h0000_0000_FFC0_0001; dbls[3]  = 1'b0; // -nan
        vals[4]  = 64'h0000_0000_0000_0000; dbls[4]  = 1'b0; // +0
        vals[5]  = 64'h0000_0000_8000_0000; dbls[5]  = 1'b0; // -0
        vals[6]  = 64'h0000_0000_0000_0001; dbls[6]  = 1'b0; // +den
        vals[7]  = 64'h0000_0000_807F_FFFF; dbls[7]  = 1'b0; // -den
        vals[8]  = 64'h0000_0000_3F80_0000; dbls[8]  = 1'b0; // normal
        vals[9]  = 64'h7FF0_0000_0000_0000; dbls[9]  = 1'b1;
        vals[10] = 64'hFFF0_0000_0000_0000; dbls[10] = 1'b1;
        vals[11] = 64'h7FF8_0000_0000_0000; dbls[11] = 1'b1;
        vals[12] = 64'hFFF0_0000_0000_0001; dbls[12] = 1'b1;
        vals[13] = 64'h0000_0000_0000_0000; dbls[13] = 1'b1;
        vals[14] = 64'h8000_0000_0000_0000; dbls[14] = 1'b1;
        vals[15] = 64'h0000_0000_0000_0001; dbls[15] = 1'b1;
        vals[16] = 64'h800F_FFFF_FFFF_FFFF; dbls[16] = 1'b1;
        vals[17] = 64'hBFF0_0000_0000_0000; dbls[17] = 1'b1; // normal

        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check(out_valid == 1'b0 && out_cond == 4'd0 && out_cr_idx == 3'd0,
              "R10 reset state", {11'd0, out_valid, out_cond}, 16'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int c = 0; c < 18; c++) begin
            string pt;
            pt = dbls[c] ? "R2" : "R1";
            drive(vals[c], dbls[c], 8'hFF, 3'(n), {pt, " R3 R5 R6 all-ones"}); n++;
            drive(vals[c], dbls[c], 8'h00, 3'(n), {pt, " R6 all-zero"}); n++;
            for (int k = 0; k < 8; k++) begin
                drive(vals[c], dbls[c], 8'h80 >> k, 3'(n), {pt, " R4 single-bit"}); n++;
            end
        end

        // R1 upper word ignored; same register as a double is a normal value
        drive(64'hDEAD_BEEF_7F80_0000, 1'b0, 8'hFF, 3'd5, "R1 upper ignored");
        drive(64'hDEAD_BEEF_7F80_0000, 1'b1, 8'hFF, 3'd6, "R2 upper used");
        drive(64'h0000_0000_7F80_0000, 1'b1, 8'hFF, 3'd7, "R2 sp-inf as double denorm");
        idle(1);

        // R1 explicit: the upper-word variant equals the clean value
        drive(64'hFFFF_FFFF_FF80_0000, 1'b0, 8'h10, 3'd1, "R1 upper ones");
        @(negedge clk);
        in_valid = 1'b0;
        check(out_cond == 4'b0010, "R1 R4 -inf with upper ones", 16'(out_cond), 16'h2);

        // R8 hold while idle
        @(negedge clk);
        check(out_valid == 1'b0 && out_cond == 4'b0010 && out_cr_idx == 3'd1,
              "R7 R8 hold while idle", {9'd0, out_valid, out_cond, out_cr_idx},
              {9'd0, 1'b0, 4'b0010, 3'd1});
        idle(2);
        check(out_cond == 4'b0010, "R8 hold after more idle", 16'(out_cond), 16'h2);

        // R10 reset wins over in_valid
        @(negedge clk);
        operand = 64'h0000_0000_7FC0_0000;
        is_double = 1'b0;
        {mask_field, mask_tail} = 8'hFF;
        cr_idx = 3'd4;
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_cond == 4'd0 && out_cr_idx == 3'd0,
              "R10 reset over in_valid", {9'd0, out_valid, out_cond, out_cr_idx}, 16'h0);
        in_valid = 1'b0;
        rst = 1'b0;

        // Back-to-back after reset
        drive(64'h0000_0000_8000_0000, 1'b0, 8'h04, 3'd2, "R1 R4 R5 -zero");
        drive(64'h8000_0000_0000_0001, 1'b1, 8'h01, 3'd3, "R2 R4 R5 -den");
        idle(3);

        check(exp_cond_q.size() == 0, "R7 queue drained",
              16'(exp_cond_q.size()), 16'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule